// File: doc/BRIEF.md
# Single-Line Read Cache Wait-State Controller

This block sits on the path between an 8-bit CPU bus and a banked RAM and decides, for every RAM read, whether the CPU must be held for extra cycles. The 64 KB CPU space is split into four 16 KB windows. Each window maps to a RAM page given by its own 8-bit page register. The controller remembers one recently fetched 512-byte line, shared by all four windows. The line is named by a 13-bit tag made of the window's page number and the top five bits of the in-window offset.

The cache only matters when the CPU runs at its fastest clock setting (clock-mode code 2). In that setting, a read that hits the remembered line proceeds at full speed. A read that misses, or that targets a window whose cache enable bit is clear, takes that read's line as the new tag and raises a wait request for two clock cycles, like a memory-ready deassertion. In every other clock setting, reads pass with no wait and no tag change. Writes only ever remove the remembered line, and only when their own tag equals it. A qualifier marks side-effect-free (debug) reads, which leave the controller untouched. While the wait request is high, the controller accepts no access.

Top module: `rdcache_wait_ctl`

## Requirements
- R1: The line tag of an access is 13 bits wide. Bits 12..5 hold the page register of the selected window (`page_regs[8*w+7:8*w]` for window w). Bits 4..0 hold `offset[13:9]`. A tag loaded by a read appears on `tag_value` in the cycle after the read is sampled.
- R2: While `rst_n` is low at a clock edge, the controller clears `tag_valid` and `wait_req` from the next cycle, and `tag_value` reads 0.
- R3: A read is taken in fast mode when `clk_mode == 2`, `rd_en` is high, `wr_en` is low, `quiet_rd` is low and `wait_req` is low. If it misses, `tag_valid` becomes 1, its tag is loaded, and `wait_req` is high for exactly the two cycles that follow the sampling edge.
- R4: In fast mode, a read from window w while `bank_cache_en[w]` is 0 always counts as a miss, even when its tag equals the valid stored tag.
- R5: In fast mode, a read from an enabled window whose tag equals the valid stored tag raises no wait and leaves the tag and valid flag unchanged.
- R6: A read made while `clk_mode` is 0, 1 or 3 raises no wait and changes neither `tag_value` nor `tag_valid`.
- R7: An accepted write whose tag equals the valid stored tag clears `tag_valid`, in any clock mode. Any other write has no effect. No write ever loads a tag or raises a wait. The tag ignores which window is used, so a write through another window that maps the same page and line also invalidates.
- R8: A read with `quiet_rd` high changes neither the tag nor the valid flag, and raises no wait.
- R9: While `wait_req` is high, `rd_en` and `wr_en` are ignored.
- R10: When `rd_en` and `wr_en` are both high, the access is handled as a write alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 2 | CPU window of the access |
| offset | input | 14 | Byte offset within the window |
| rd_en | input | 1 | RAM read strobe |
| wr_en | input | 1 | RAM write strobe |
| quiet_rd | input | 1 | Marks a side-effect-free read |
| page_regs | input | 32 | Four 8-bit page numbers, window w in bits 8w+7..8w |
| clk_mode | input | 2 | CPU clock-mode code, 2 = fastest |
| bank_cache_en | input | 4 | Per-window cache enable, bit w for window w |
| wait_req | output | 1 | Hold request to the CPU |
| tag_valid | output | 1 | Stored line tag is valid |
| tag_value | output | 13 | Stored line tag |

## Verification
The hardest case to reach from the ports is a write that hits the stored line through a different window than the one that loaded it. The stimulus creates it by setting two page registers to the same page and writing at the same upper offset bits through the second window. A second case is a disabled window whose read tag already equals the valid stored tag. The bench reaches it by loading the line through an enabled window and then clearing that window's enable bit before reading the same line again. Accesses issued during the two wait cycles are driven back-to-back directly after a miss. A long constrained-random phase keeps offsets within a few lines, so hits, misses and invalidations mix densely.

// File: rtl/rdc_pkg.sv
// Package: shared constants and types of the read cache wait-state controller.
// Assumes four CPU windows of 16 KB and 512-byte lines; all derived widths follow.
package rdc_pkg;
    localparam int NUM_BANKS   = 4;
    localparam int PAGE_W      = 8;
    localparam int OFS_W       = 14;
    localparam int LINE_SHIFT  = 9;
    localparam int MODE_W      = 2;
    localparam int FAST_MODE   = 2;
    localparam int WAIT_CYCLES = 2;

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int LINE_W = OFS_W - LINE_SHIFT;
    localparam int TAG_W  = PAGE_W + LINE_W;
    localparam int CNT_W  = $clog2(WAIT_CYCLES + 1);

    // Kind of access accepted in a given cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_QUIET = 2'd3
    } acc_kind_t;
endpackage

// File: rtl/rdc_line_tag.sv
// Module: rdc_line_tag
// Forms the line tag of the current access: the page of the selected window
// above the upper offset bits. Purely combinational.
// Assumes NUM_BANKS is a power of two so bank_sel indexes every entry.
module rdc_line_tag #(
    parameter int NUM_BANKS  = rdc_pkg::NUM_BANKS,
    parameter int PAGE_W     = rdc_pkg::PAGE_W,
    parameter int OFS_W      = rdc_pkg::OFS_W,
    parameter int LINE_SHIFT = rdc_pkg::LINE_SHIFT,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int TAG_W     = PAGE_W + OFS_W - LINE_SHIFT
) (
    input  logic [BANK_W-1:0]           bank_sel,
    input  logic [NUM_BANKS*PAGE_W-1:0] page_regs,
    input  logic [OFS_W-1:0]            offset,
    output logic [TAG_W-1:0]            line_tag
);
    logic [PAGE_W-1:0] page_arr [NUM_BANKS];
    logic [PAGE_W-1:0] cur_page;

    // Split the flat page register bus into one entry per window
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_page
        assign page_arr[g] = page_regs[g*PAGE_W +: PAGE_W];
    end

    // Pick the selected window's page and drop the in-line byte bits
    always_comb begin
        cur_page = page_arr[bank_sel];
        line_tag = TAG_W'({cur_page, offset} >> LINE_SHIFT);
    end
endmodule

// File: rtl/rdc_tag_store.sv
// Module: rdc_tag_store
// Holds the single stored line tag and its valid flag, and compares a probe tag.
// Assumes load and invalidate are never requested in the same cycle.
module rdc_tag_store #(
    parameter int TAG_W = rdc_pkg::TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             invalidate,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             match,
    output logic             tag_valid,
    output logic [TAG_W-1:0] tag_value
);
    // Tag register: loaded on a read miss, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag_value <= '0;
        else if (load)
            tag_value <= probe_tag;
    end

    // Valid flag: set by a load, cleared by reset or a matching write
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag_valid <= 1'b0;
        else if (load)
            tag_valid <= 1'b1;
        else if (invalidate)
            tag_valid <= 1'b0;
    end

    // A match needs a valid entry, so no tag value can hit after invalidation
    always_comb match = tag_valid && (tag_value == probe_tag);
endmodule

// File: rtl/rdc_wait_timer.sv
// Module: rdc_wait_timer
// Counts out the wait-state penalty and reports busy while it runs.
// Assumes start is only asserted while busy is low.
module rdc_wait_timer #(
    parameter int WAIT_CYCLES = rdc_pkg::WAIT_CYCLES,
    localparam int CNT_W      = $clog2(WAIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] remain;

    // Down-counter: reload on start, count to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= CNT_W'(WAIT_CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    // Busy is the registered count being non-zero: no combinational path from start
    always_comb busy = (remain != '0);
endmodule

// File: rtl/rdcache_wait_ctl.sv
// Module: rdcache_wait_ctl (top)
// Decides per RAM read whether wait states are needed, using one line tag shared
// by every CPU window. Penalties apply only in the fastest clock mode; writes
// only invalidate. Assumes the CPU stalls while wait_req is high and repeats
// the access afterwards; accesses seen while wait_req is high are dropped.
module rdcache_wait_ctl
    import rdc_pkg::*;
#(
    parameter int P_NUM_BANKS   = NUM_BANKS,
    parameter int P_PAGE_W      = PAGE_W,
    parameter int P_OFS_W       = OFS_W,
    parameter int P_LINE_SHIFT  = LINE_SHIFT,
    parameter int P_MODE_W      = MODE_W,
    parameter int P_FAST_MODE   = FAST_MODE,
    parameter int P_WAIT_CYCLES = WAIT_CYCLES,
    localparam int L_BANK_W     = $clog2(P_NUM_BANKS),
    localparam int L_TAG_W      = P_PAGE_W + P_OFS_W - P_LINE_SHIFT
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [L_BANK_W-1:0]               bank_sel,
    input  logic [P_OFS_W-1:0]                offset,
    input  logic                              rd_en,
    input  logic                              wr_en,
    input  logic                              quiet_rd,
    input  logic [P_NUM_BANKS*P_PAGE_W-1:0]   page_regs,
    input  logic [P_MODE_W-1:0]               clk_mode,
    input  logic [P_NUM_BANKS-1:0]            bank_cache_en,
    output logic                              wait_req,
    output logic                              tag_valid,
    output logic [L_TAG_W-1:0]                tag_value
);
    logic [L_TAG_W-1:0] cur_tag;
    logic               tag_match;
    logic               fast_mode;
    logic               bank_en;
    acc_kind_t          acc_kind;
    logic               do_load;
    logic               do_inval;

    rdc_line_tag #(
        .NUM_BANKS  (P_NUM_BANKS),
        .PAGE_W     (P_PAGE_W),
        .OFS_W      (P_OFS_W),
        .LINE_SHIFT (P_LINE_SHIFT)
    ) u_line_tag (
        .bank_sel  (bank_sel),
        .page_regs (page_regs),
        .offset    (offset),
        .line_tag  (cur_tag)
    );

    rdc_tag_store #(
        .TAG_W (L_TAG_W)
    ) u_tag_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (do_load),
        .invalidate (do_inval),
        .probe_tag  (cur_tag),
        .match      (tag_match),
        .tag_valid  (tag_valid),
        .tag_value  (tag_value)
    );

    rdc_wait_timer #(
        .WAIT_CYCLES (P_WAIT_CYCLES)
    ) u_wait_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (do_load),
        .busy  (wait_req)
    );

    // Classify the access of this cycle; a write wins over a read, busy drops all
    always_comb begin
        if (wait_req)
            acc_kind = ACC_NONE;
        else if (wr_en)
            acc_kind = ACC_WRITE;
        else if (rd_en && quiet_rd)
            acc_kind = ACC_QUIET;
        else if (rd_en)
            acc_kind = ACC_READ;
        else
            acc_kind = ACC_NONE;
    end

    // Derive the tag store and timer controls from the access kind
    always_comb begin
        fast_mode = (clk_mode == P_MODE_W'(P_FAST_MODE));
        bank_en   = bank_cache_en[bank_sel];
        do_load   = (acc_kind == ACC_READ) && fast_mode && !(bank_en && tag_match);
        do_inval  = (acc_kind == ACC_WRITE) && tag_match;
    end
endmodule

// File: rtl/rdc_checker.sv
// Module: rdc_checker
// Temporal checks of the controller, attached to every instance by bind.
// Works from the top-level ports only and recomputes the access tag itself.
module rdc_checker #(
    parameter int NUM_BANKS  = rdc_pkg::NUM_BANKS,
    parameter int PAGE_W     = rdc_pkg::PAGE_W,
    parameter int OFS_W      = rdc_pkg::OFS_W,
    parameter int LINE_SHIFT = rdc_pkg::LINE_SHIFT,
    parameter int MODE_W     = rdc_pkg::MODE_W,
    parameter int FAST_MODE  = rdc_pkg::FAST_MODE,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int LINE_W    = OFS_W - LINE_SHIFT,
    localparam int TAG_W     = PAGE_W + LINE_W
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [BANK_W-1:0]            bank_sel,
    input logic [OFS_W-1:0]             offset,
    input logic                         rd_en,
    input logic                         wr_en,
    input logic                         quiet_rd,
    input logic [NUM_BANKS*PAGE_W-1:0]  page_regs,
    input logic [MODE_W-1:0]            clk_mode,
    input logic [NUM_BANKS-1:0]         bank_cache_en,
    input logic                         wait_req,
    input logic                         tag_valid,
    input logic [TAG_W-1:0]             tag_value
);
    logic [TAG_W-1:0] calc_tag;
    logic             same_line;
    logic             rd_go;
    logic             wr_go;
    logic             fast;

    // Independent reconstruction of the access tag and the accepted access
    always_comb begin
        calc_tag  = {page_regs[bank_sel*PAGE_W +: PAGE_W], offset[OFS_W-1:LINE_SHIFT]};
        same_line = tag_valid && (tag_value == calc_tag);
        fast      = (clk_mode == MODE_W'(FAST_MODE));
        rd_go     = rd_en && !wr_en && !quiet_rd && !wait_req;
        wr_go     = wr_en && !wait_req;
    end

    assert_reset_clear_R2: assert property (@(posedge clk)
        !rst_n |=> (!tag_valid && !wait_req && tag_value == '0));

    // R1 and R3: a miss loads the recomputed tag and starts the wait
    assert_miss_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && fast && !(bank_cache_en[bank_sel] && same_line))
        |=> (wait_req && tag_valid && tag_value == $past(calc_tag)));

    assert_wait_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_req) |=> wait_req);

    assert_wait_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && $past(wait_req)) |=> !wait_req);

    assert_disabled_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && fast && !bank_cache_en[bank_sel]) |=> wait_req);

    assert_hit_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && fast && bank_cache_en[bank_sel] && same_line)
        |=> (!wait_req && tag_valid && $stable(tag_value)));

    assert_slow_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !fast)
        |=> (!wait_req && $stable(tag_value) && $stable(tag_valid)));

    assert_write_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && same_line) |=> !tag_valid);

    // R7 and R10: a write, alone or together with a read, never loads or waits
    assert_write_noload_R7_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (!wait_req && $stable(tag_value) && !$rose(tag_valid)));

    assert_quiet_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && quiet_rd && !wait_req)
        |=> (!wait_req && $stable(tag_value) && $stable(tag_valid)));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |=> ($stable(tag_value) && $stable(tag_valid)));
endmodule

bind rdcache_wait_ctl rdc_checker #(
    .NUM_BANKS  (P_NUM_BANKS),
    .PAGE_W     (P_PAGE_W),
    .OFS_W      (P_OFS_W),
    .LINE_SHIFT (P_LINE_SHIFT),
    .MODE_W     (P_MODE_W),
    .FAST_MODE  (P_FAST_MODE)
) u_rdc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bank_sel      (bank_sel),
    .offset        (offset),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .quiet_rd      (quiet_rd),
    .page_regs     (page_regs),
    .clk_mode      (clk_mode),
    .bank_cache_en (bank_cache_en),
    .wait_req      (wait_req),
    .tag_valid     (tag_valid),
    .tag_value     (tag_value)
);

// File: tb/tb_rdcache_wait_ctl.sv
// Bench: behavioural reference model compared with the outputs on every clock.
module tb_rdcache_wait_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic [13:0] offset = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        quiet_rd = 1'b0;
    logic [31:0] page_regs;
    logic [1:0]  clk_mode = 2'd2;
    logic [3:0]  bank_cache_en = 4'hF;
    logic        wait_req;
    logic        tag_valid;
    logic [12:0] tag_value;

    logic [7:0] pg [4];

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string cur_req  = "R2";

    // Reference model state
    int m_valid = 0;
    int m_tag   = 0;
    int m_wait  = 0;

    always_comb page_regs = {pg[3], pg[2], pg[1], pg[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    rdcache_wait_ctl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bank_sel      (bank_sel),
        .offset        (offset),
        .rd_en         (rd_en),
        .wr_en         (wr_en),
        .quiet_rd      (quiet_rd),
        .page_regs     (page_regs),
        .clk_mode      (clk_mode),
        .bank_cache_en (bank_cache_en),
        .wait_req      (wait_req),
        .tag_valid     (tag_valid),
        .tag_value     (tag_value)
    );

    function automatic int tag_of(int b, int ofs);
        return pg[b] * 32 + (ofs / 512);
    endfunction

    // Advance the model by one edge using the inputs currently driven
    task automatic model_step();
        int t;
        t = tag_of(int'(bank_sel), int'(offset));
        if (!rst_n) begin
            m_valid = 0; m_tag = 0; m_wait = 0;
        end else if (m_wait > 0) begin
            m_wait = m_wait - 1;                       // R9: access dropped
        end else if (wr_en) begin                      // R10: write wins
            if (m_valid == 1 && m_tag == t) m_valid = 0;
        end else if (rd_en && !quiet_rd && clk_mode == 2'd2) begin
            if (!(bank_cache_en[bank_sel] && m_valid == 1 && m_tag == t)) begin
                m_tag = t; m_valid = 1; m_wait = 2;
            end
        end
    endtask

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cycles);
        end
    endtask

    task automatic compare();
        check("wait_req", int'(wait_req), (m_wait > 0) ? 1 : 0);
        check("tag_valid", int'(tag_valid), m_valid);
        check("tag_value", int'(tag_value), m_tag);
    endtask

    // One clock: drive, edge, model, then compare at the falling edge
    task automatic op(logic rd, logic wr, logic q, int b, int ofs);
        rd_en = rd; wr_en = wr; quiet_rd = q;
        bank_sel = 2'(b); offset = 14'(ofs);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 1'b0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        pg[0] = 8'h11; pg[1] = 8'h22; pg[2] = 8'hA5; pg[3] = 8'hFF;
        @(negedge clk);

        // R2: reset clears everything even with reads offered
        cur_req = "R2";
        op(1'b1, 1'b0, 1'b0, 2, 14'h3E00);
        op(1'b1, 1'b0, 1'b0, 1, 14'h0200);
        op(1'b0, 1'b0, 1'b0, 0, 0);
        rst_n = 1'b1;
        idle(2);

        // R1, R3: miss in fast mode loads {page, offset[13:9]} and waits two cycles
        cur_req = "R1";
        clk_mode = 2'd2; bank_cache_en = 4'hF;
        op(1'b1, 1'b0, 1'b0, 2, 14'h3E00);     // tag 0xA5*32+31
        cur_req = "R3";
        idle(3);
        op(1'b1, 1'b0, 1'b0, 3, 14'h2A15);     // new line, miss
        idle(3);

        // R5: hits inside the same 512-byte line
        cur_req = "R5";
        op(1'b1, 1'b0, 1'b0, 3, 14'h2BFF);
        op(1'b1, 1'b0, 1'b0, 3, 14'h2A00);
        op(1'b1, 1'b0, 1'b0, 3, 14'h2C00);     // next line: miss
        idle(2);

        // R9: back-to-back accesses during the wait are dropped
        cur_req = "R9";
        op(1'b1, 1'b0, 1'b0, 0, 14'h0000);     // miss
        op(1'b1, 1'b0, 1'b0, 1, 14'h1000);     // ignored
        op(1'b0, 1'b1, 1'b0, 0, 14'h0000);     // ignored write to tagged line
        op(1'b1, 1'b0, 1'b0, 0, 14'h0010);     // hit afterwards
        idle(1);

        // R4: disabled window always misses, even with a matching tag
        cur_req = "R4";
        op(1'b1, 1'b0, 1'b0, 2, 14'h0400);
        idle(2);
        bank_cache_en = 4'b1011;
        op(1'b1, 1'b0, 1'b0, 2, 14'h0400);
        idle(2);
        op(1'b1, 1'b0, 1'b0, 2, 14'h05FF);
        idle(2);
        bank_cache_en = 4'hF;

        // R6: slow clock modes never wait nor retag
        cur_req = "R6";
        for (int m = 0; m < 4; m++) begin
            if (m != 2) begin
                clk_mode = 2'(m);
                op(1'b1, 1'b0, 1'b0, 1, 14'h3000);
                op(1'b1, 1'b0, 1'b0, 2, 14'h0400);
            end
        end
        clk_mode = 2'd2;

        // R7: non-matching write, matching write, write in slow mode, cross-window alias
        cur_req = "R7";
        op(1'b1, 1'b0, 1'b0, 1, 14'h1200);
        idle(2);
        op(1'b0, 1'b1, 1'b0, 1, 14'h1400);     // other line: no effect
        op(1'b0, 1'b1, 1'b0, 1, 14'h13FF);     // same line: invalidate
        op(1'b0, 1'b1, 1'b0, 1, 14'h1200);     // already invalid
        op(1'b1, 1'b0, 1'b0, 1, 14'h1200);     // miss again
        idle(2);
        clk_mode = 2'd0;
        op(1'b0, 1'b1, 1'b0, 1, 14'h1300);     // invalidate in slow mode
        clk_mode = 2'd2;
        op(1'b1, 1'b0, 1'b0, 0, 14'h0800);
        idle(2);
        pg[3] = 8'h11;                         // window 3 aliases window 0's page
        op(1'b0, 1'b1, 1'b0, 3, 14'h0900);     // same page and line via window 3
        op(1'b1, 1'b0, 1'b0, 0, 14'h0800);     // miss after alias invalidation
        idle(2);
        pg[3] = 8'hFF;

        // R8: quiet reads leave all state alone
        cur_req = "R8";
        op(1'b1, 1'b0, 1'b1, 2, 14'h2000);
        op(1'b1, 1'b0, 1'b1, 0, 14'h0800);
        bank_cache_en = 4'h0;
        op(1'b1, 1'b0, 1'b1, 0, 14'h0800);
        bank_cache_en = 4'hF;

        // R10: read and write together act as a write only
        cur_req = "R10";
        op(1'b1, 1'b1, 1'b0, 2, 14'h2000);     // would miss as a read
        op(1'b1, 1'b1, 1'b0, 0, 14'h0800);     // invalidates the line
        op(1'b1, 1'b0, 1'b0, 0, 14'h0800);
        idle(2);

        // Mixed constrained-random traffic
        cur_req = "R3";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (i % 500 == 0) begin
                clk_mode = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd2;
                bank_cache_en = 4'($urandom_range(0, 15));
                pg[$urandom_range(0, 3)] = 8'($urandom_range(16, 19));
            end
            op(r < 60, r >= 50 && r < 80, r >= 90, int'($urandom_range(0, 3)),
               int'($urandom_range(0, 3)) * 512 + int'($urandom_range(0, 511)));
        end
        idle(3);

        finish_run();
    end
endmodule